// File: doc/BRIEF.md
# Delayed Write Termination Handler

This block sits in a bridge between the engine that replays a delayed write on the far bus and the logic that answers the original initiator. It accepts a new delayed write only while it is idle. It then takes one termination code for each write attempt from the target-side engine. For each code it decides whether the write must be tried again or is finished, and it emits a one-cycle response code for the initiator side.

Attempts answered with a retry are counted. The count is compared with one of two limits: the low limit is 2^LIM_LO_W and the high limit is 2^LIM_HI_W, chosen by `limit_sel`. When the last permitted attempt is also answered with a retry, the write is dropped. In that case a one-cycle system-error request is raised, provided the error enable is set and the non-delivery event is not masked. A target abort sets two sticky status flags, one for each side of the bridge. Each flag is cleared by writing a one to its own strobe.

Top module: `dwr_term_ctl`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `rx_tabort`, `sig_tabort` and `serr_req` are 0. A `req_valid` seen while idle makes `busy` 1 on the next cycle, latches `req_multi` and clears the retry count. A `req_valid` seen while busy is ignored.
- R2: A termination code `att_code` is taken only when `att_valid` is high while busy. Each code taken gives exactly one `rsp_valid` pulse on the next cycle.
- R3: Code 0 (normal completion) gives response 1 (disconnect) if the latched multi-phase flag is set, otherwise response 0 (complete). The block then returns to idle.
- R4: Code 2 (target disconnect) gives the same responses as code 0 and also returns to idle.
- R5: Code 1 (retry) gives response 2 (retry) and the block stays busy, as long as the limit has not been reached.
- R6: When `limit_sel` is 0, the 2^LIM_LO_W-th retry of the same write gives response 5 (dropped) and returns to idle. When `limit_sel` is 1, this happens on the 2^LIM_HI_W-th retry.
- R7: Code 4 (target abort) gives response 3 (target abort), sets `rx_tabort` and `sig_tabort`, and returns to idle.
- R8: Code 3 (master abort) gives response 4 (master abort), returns to idle and leaves both status flags unchanged.
- R9: `serr_req` pulses for one cycle, together with response 5, only when `serr_en` is 1 and `nodeliv_mask` is 0 in the cycle the final retry is taken.
- R10: Each status flag holds until its clear strobe is high. A new target abort arriving in the same cycle as the strobe wins, so the flag stays set.
- R11: `att_valid` while idle produces no response and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New delayed write accepted |
| req_multi | input | 1 | Initiator asked for more than one data phase |
| att_valid | input | 1 | Attempt termination is present |
| att_code | input | 3 | 0 normal, 1 retry, 2 disconnect, 3 master abort, 4 target abort |
| limit_sel | input | 1 | 0 selects the low retry limit, 1 the high one |
| serr_en | input | 1 | System-error enable |
| nodeliv_mask | input | 1 | Masks the non-delivery error event |
| clr_rx_tabort | input | 1 | Write-one-to-clear for `rx_tabort` |
| clr_sig_tabort | input | 1 | Write-one-to-clear for `sig_tabort` |
| busy | output | 1 | A delayed write is in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 3 | 0 complete, 1 disconnect, 2 retry, 3 target abort, 4 master abort, 5 dropped |
| rx_tabort | output | 1 | Target-side received-target-abort flag |
| sig_tabort | output | 1 | Initiator-side signaled-target-abort flag |
| serr_req | output | 1 | System-error request pulse |

## Verification
Normal and disconnect terminations are each driven with the multi-phase flag both set and clear, which separates the disconnect response from the plain completion. Runs of retries are taken to exactly one below each of the two limits and then onto the limit itself. Running back to back shows that the count restarts with each new write. Running under the three combinations of enable and mask isolates the error gating. Aborts, clear strobes that arrive alone or together with a new abort, and stray terminations or requests in the wrong state show that the flags, the sticky behaviour and the ignore rules are independent of one another.

// File: rtl/dwr_term_ctl.sv
module dwr_term_ctl #(
  parameter int LIM_LO_W = 24,
  parameter int LIM_HI_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_multi,
  input  logic       att_valid,
  input  logic [2:0] att_code,
  input  logic       limit_sel,
  input  logic       serr_en,
  input  logic       nodeliv_mask,
  input  logic       clr_rx_tabort,
  input  logic       clr_sig_tabort,
  output logic       busy,
  output logic       rsp_valid,
  output logic [2:0] rsp_code,
  output logic       rx_tabort,
  output logic       sig_tabort,
  output logic       serr_req
);
  localparam int CW = LIM_HI_W;
  localparam logic [CW-1:0] LAST_LO = {{(CW-LIM_LO_W){1'b0}}, {LIM_LO_W{1'b1}}};
  localparam logic [CW-1:0] LAST_HI = '1;

  logic          multi_q;
  logic [CW-1:0] cnt_q;

  wire take     = busy && att_valid;
  wire at_last  = cnt_q == (limit_sel ? LAST_HI : LAST_LO);
  wire is_retry = att_code == 3'd1;
  wire is_tab   = att_code == 3'd4;
  wire dropped  = take && is_retry && at_last;
  wire stay     = take && is_retry && !at_last;

  logic [2:0] rsp_n;
  always_comb begin
    case (att_code)
      3'd0, 3'd2: rsp_n = multi_q ? 3'd1 : 3'd0;
      3'd1:       rsp_n = at_last ? 3'd5 : 3'd2;
      3'd4:       rsp_n = 3'd3;
      default:    rsp_n = 3'd4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      multi_q    <= 1'b0;
      cnt_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_code   <= 3'd0;
      rx_tabort  <= 1'b0;
      sig_tabort <= 1'b0;
      serr_req   <= 1'b0;
    end else begin
      rsp_valid <= take;
      serr_req  <= dropped && serr_en && !nodeliv_mask;
      if (take) rsp_code <= rsp_n;
      if (!busy && req_valid) begin
        busy    <= 1'b1;
        multi_q <= req_multi;
        cnt_q   <= '0;
      end else if (stay) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (take) begin
        busy <= 1'b0;
      end
      if (take && is_tab) begin
        rx_tabort  <= 1'b1;
        sig_tabort <= 1'b1;
      end else begin
        if (clr_rx_tabort)  rx_tabort  <= 1'b0;
        if (clr_sig_tabort) sig_tabort <= 1'b0;
      end
    end
  end
endmodule

module dwr_term_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       att_valid,
  input logic [2:0] att_code,
  input logic       serr_en,
  input logic       nodeliv_mask,
  input logic       clr_rx_tabort,
  input logic       clr_sig_tabort,
  input logic       busy,
  input logic       rsp_valid,
  input logic [2:0] rsp_code,
  input logic       rx_tabort,
  input logic       sig_tabort,
  input logic       serr_req
);
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid |=> busy);
  a_r5_retry: assert property (@(posedge clk) disable iff (!rst_n)
    busy && att_valid && att_code == 3'd1 |=>
      rsp_valid && ((rsp_code == 3'd2 && busy) || (rsp_code == 3'd5 && !busy)));
  a_r7_tabort: assert property (@(posedge clk) disable iff (!rst_n)
    busy && att_valid && att_code == 3'd4 |=>
      rsp_valid && rsp_code == 3'd3 && rx_tabort && sig_tabort && !busy);
  a_r8_mabort: assert property (@(posedge clk) disable iff (!rst_n)
    busy && att_valid && att_code == 3'd3 |=>
      rsp_valid && rsp_code == 3'd4 && !busy &&
      rx_tabort == $past(rx_tabort && !clr_rx_tabort) &&
      sig_tabort == $past(sig_tabort && !clr_sig_tabort));
  a_r9_serr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> rsp_valid && rsp_code == 3'd5 && $past(serr_en && !nodeliv_mask));
  a_r10_sticky_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tabort && !clr_rx_tabort |=> rx_tabort);
  a_r10_sticky_sig: assert property (@(posedge clk) disable iff (!rst_n)
    sig_tabort && !clr_sig_tabort |=> sig_tabort);
  a_r11_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rsp_valid);
endmodule

bind dwr_term_ctl dwr_term_chk u_dwr_term_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .att_valid(att_valid),
  .att_code(att_code), .serr_en(serr_en), .nodeliv_mask(nodeliv_mask),
  .clr_rx_tabort(clr_rx_tabort), .clr_sig_tabort(clr_sig_tabort),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rx_tabort(rx_tabort), .sig_tabort(sig_tabort), .serr_req(serr_req)
);

// File: tb/dwr_term_ctl_bench.sv
module dwr_term_ctl_bench;
  localparam int LO = 3;
  localparam int HI = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_multi = 0, att_valid = 0, limit_sel = 0;
  logic serr_en = 0, nodeliv_mask = 0, clr_rx_tabort = 0, clr_sig_tabort = 0;
  logic [2:0] att_code = 0;
  logic busy, rsp_valid, rx_tabort, sig_tabort, serr_req;
  logic [2:0] rsp_code;

  int compared = 0, mismatched = 0;
  logic [3:0] exp_q[$];

  always #2 clk = ~clk;

  dwr_term_ctl #(.LIM_LO_W(LO), .LIM_HI_W(HI)) u_dwr_term_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_multi(req_multi),
    .att_valid(att_valid), .att_code(att_code), .limit_sel(limit_sel),
    .serr_en(serr_en), .nodeliv_mask(nodeliv_mask),
    .clr_rx_tabort(clr_rx_tabort), .clr_sig_tabort(clr_sig_tabort),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rx_tabort(rx_tabort), .sig_tabort(sig_tabort), .serr_req(serr_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2/R11 unexpected response", {serr_req, rsp_code}, -1);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk({serr_req, rsp_code} == e, "R2-scoreboard {serr,rsp}", {serr_req, rsp_code}, e);
      end
    end else if (serr_req) chk(0, "R9 serr without response", 1, 0);
  end

  task automatic start(input logic m);
    @(negedge clk); req_valid = 1; req_multi = m;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic term(input logic [2:0] c, input logic [2:0] er, input logic es);
    @(negedge clk); att_valid = 1; att_code = c; exp_q.push_back({es, er});
    @(negedge clk); att_valid = 0;
  endtask

  task automatic retries(input int n);
    for (int i = 0; i < n; i++) term(3'd1, 3'd2, 1'b0);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_valid && !rx_tabort && !sig_tabort && !serr_req, "R1 reset", busy, 0);
    // R11 termination while idle
    @(negedge clk); att_valid = 1; att_code = 3'd0;
    @(negedge clk); att_valid = 0;
    @(negedge clk);
    chk(!busy, "R11 idle ignore", busy, 0);
    // R3 normal completion
    start(1); chk(busy, "R1 accept", busy, 1);
    term(3'd0, 3'd1, 0); chk(!busy, "R3 idle after normal", busy, 0);
    start(0); term(3'd0, 3'd0, 0);
    // R4 disconnect
    start(1); term(3'd2, 3'd1, 0); chk(!busy, "R4 idle", busy, 0);
    start(0); term(3'd2, 3'd0, 0);
    // R5 retries, R1 request while busy ignored, R8 master abort
    start(1); retries(3); chk(busy, "R5 stays busy", busy, 1);
    @(negedge clk); req_valid = 1; req_multi = 0;
    @(negedge clk); req_valid = 0;
    term(3'd0, 3'd1, 0);
    start(0); retries(2); term(3'd3, 3'd4, 0);
    chk(!busy && !rx_tabort && !sig_tabort, "R8 master abort", {busy, rx_tabort, sig_tabort}, 0);
    // R6 low limit with R9 gating
    serr_en = 1; nodeliv_mask = 0; limit_sel = 0;
    start(0); retries((1 << LO) - 1); chk(busy, "R6 one below low limit", busy, 1);
    term(3'd1, 3'd5, 1); chk(!busy, "R6 dropped idle", busy, 0);
    nodeliv_mask = 1;
    start(1); retries((1 << LO) - 1); term(3'd1, 3'd5, 0);
    nodeliv_mask = 0; serr_en = 0;
    start(1); retries((1 << LO) - 1); term(3'd1, 3'd5, 0);
    // R6 high limit
    serr_en = 1; limit_sel = 1;
    start(0); retries((1 << HI) - 1); chk(busy, "R6 one below high limit", busy, 1);
    term(3'd1, 3'd5, 1); chk(!busy, "R6 high dropped", busy, 0);
    limit_sel = 0;
    // R7 target abort, R10 clears
    start(1); term(3'd4, 3'd3, 0);
    chk(rx_tabort && sig_tabort && !busy, "R7 flags", {rx_tabort, sig_tabort}, 3);
    @(negedge clk); clr_rx_tabort = 1;
    @(negedge clk); clr_rx_tabort = 0;
    chk(!rx_tabort && sig_tabort, "R10 clear rx only", {rx_tabort, sig_tabort}, 1);
    @(negedge clk); clr_sig_tabort = 1;
    @(negedge clk); clr_sig_tabort = 0;
    chk(!rx_tabort && !sig_tabort, "R10 clear sig", {rx_tabort, sig_tabort}, 0);
    start(0);
    @(negedge clk); att_valid = 1; att_code = 3'd4; exp_q.push_back({1'b0, 3'd3});
    clr_rx_tabort = 1; clr_sig_tabort = 1;
    @(negedge clk); att_valid = 0; clr_rx_tabort = 0; clr_sig_tabort = 0;
    chk(rx_tabort && sig_tabort, "R10 set wins", {rx_tabort, sig_tabort}, 3);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule